// File: doc/BRIEF.md
# Serial RTC Register Slave

This block is the register side of a real-time clock. A host reaches it over a three-wire serial link: a frame-enable line, a serial clock and a serial data input. A serial data output and a ready flag complete the link. Behind the link sit a free-running 32-bit seconds counter, a seconds-adjust word and four 32-bit retention words. The counter advances on a one-cycle tick pulse that some other logic produces once per second.

The host opens a frame by raising the frame enable. It shifts bits in on rising serial-clock edges, most significant bit first. It then drops the enable and gives one more clock pulse, which carries the direction bit. For a write, the frame holds 32 data bits followed by 3 address bits, and a direction bit of 1 commits the write. For a read, the frame holds only the 3 address bits and the direction bit is 0. The selected word then leaves on the data output over the next 32 serial-clock rising edges. The serial lines are asynchronous to the system clock and are sampled by it, so a serial clock period must span several system clocks.

Top module: `rtc_ser_slave`

## Requirements
- R1: After a synchronous reset, `ready_o` is 1 and `sdo_o` is 0. The counter, the adjust word and all four retention words read back as 0.
- R2: A frame is a write when all of the following hold. It carries 35 bits while the enable is high: 32 data bits, then 3 address bits, each field MSB first. The enable then drops, and the next rising serial-clock edge samples a direction bit of 1. The write then stores the data at the address.
- R3: `ready_o` goes low while a frame is open and stays low until the transfer ends. A write ends at its direction bit. A read ends at the 32nd output bit. `ready_o` is high whenever the link is idle.
- R4: A frame is a read when it carries at least 3 bits while the enable is high and its direction bit is 0. The address is the last 3 bits received. The word is then driven on `sdo_o` MSB first. Bit 31-k is valid after the (k+1)-th following rising serial-clock edge and holds until the next such edge.
- R5: The address map is as follows. Address 0 is the seconds counter and address 2 is the adjust word. Addresses 4, 5, 6 and 7 are retention words 0 to 3. Addresses 1 and 3 read as zero, and writes to them change no register.
- R6: The adjust word is plain read/write storage. Writing it never changes the counter value.
- R7: A write to address 0 loads the counter. Each `tick_i` pulse adds one, wrapping from 0xFFFFFFFF to 0. Without a tick or a write the counter holds.
- R8: A direction bit of 1 after fewer than 35 enable-high bits is discarded, and every register keeps its value.
- R9: The serial inputs are re-timed to `clk`. `sdi_i` is taken at the rising serial-clock edge, so it must be set up while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from host |
| sen_i | input | 1 | Frame enable from host |
| sdi_i | input | 1 | Serial data from host |
| tick_i | input | 1 | One-cycle pulse per second |
| sdo_o | output | 1 | Serial read data to host |
| ready_o | output | 1 | Link idle, host may start a frame |

## Verification
Every storage address is written and then read back with values such as alternating bits, all ones, a single set MSB and a single set LSB. These patterns separate a bit-order fault or an off-by-one in the frame split from a correct decode. Writes to addresses 1 and 3 are followed by reads of those addresses and of the neighbouring stored words. These show that a mis-decoded address neither aliases onto real storage nor corrupts it. Further tests cover counter load, counting by tick and wrap at all ones, and a short write frame that must be dropped. A behavioural model holds the expected register contents, and the ready flag is compared against it on every idle clock.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_DIR   = 3'd2,
    ST_RWAIT = 3'd3,
    ST_LOAD  = 3'd4,
    ST_OUT   = 3'd5
  } fr_state_e;
endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
  parameter int NUM    = 3,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] din,
  output logic [NUM-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rtc_ser_regs.sv
module rtc_ser_regs #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int MEM_WORDS = 4,
  parameter int MEM_BASE  = 4,
  parameter int CNT_ADDR  = 0,
  parameter int ADJ_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int MEM_AW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [DATA_W-1:0] cnt_q, adj_q;
  logic [DATA_W-1:0] mem_q [MEM_WORDS];

  logic wr_cnt, wr_adj, wr_in_mem, rd_in_mem;
  logic [MEM_AW-1:0] wr_idx, rd_idx;
  logic [DATA_W-1:0] rd_mux;

  assign wr_cnt    = wr_en && (int'(wr_addr) == CNT_ADDR);
  assign wr_adj    = wr_en && (int'(wr_addr) == ADJ_ADDR);
  assign wr_in_mem = (int'(wr_addr) >= MEM_BASE) && (int'(wr_addr) < MEM_BASE + MEM_WORDS);
  assign rd_in_mem = (int'(rd_addr) >= MEM_BASE) && (int'(rd_addr) < MEM_BASE + MEM_WORDS);
  assign wr_idx    = MEM_AW'(int'(wr_addr) - MEM_BASE);
  assign rd_idx    = MEM_AW'(int'(rd_addr) - MEM_BASE);

  // seconds counter: a load wins over a tick in the same cycle
  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (tick)   cnt_q <= cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         adj_q <= '0;
    else if (wr_adj) adj_q <= wr_data;
  end

  genvar g;
  generate
    for (g = 0; g < MEM_WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          mem_q[g] <= '0;
        else if (wr_en && wr_in_mem && (int'(wr_idx) == g))
          mem_q[g] <= wr_data;
      end
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (rd_in_mem)                         rd_mux = mem_q[rd_idx];
    else if (int'(rd_addr) == CNT_ADDR)    rd_mux = cnt_q;
    else if (int'(rd_addr) == ADJ_ADDR)    rd_mux = adj_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R7: tick alone advances by exactly one
  a_r7_tick_inc: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));
  // R7: no tick and no load keeps the counter
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(cnt_q));
  // R6: adjust word changes only on its own write
  a_r6_adj_keep: assert property (@(posedge clk) disable iff (rst)
    !wr_adj |=> $stable(adj_q));
  // R5: unmapped addresses read zero
  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_in_mem && int'(rd_addr) != CNT_ADDR && int'(rd_addr) != ADJ_ADDR)
    |=> (rd_data == '0));
endmodule

// File: rtl/rtc_ser_frame.sv
module rtc_ser_frame
  import rtc_ser_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sen_s,
  input  logic              sdi_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              ready
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int LEFT_W  = $clog2(DATA_W + 1);

  fr_state_e state_q, state_n;
  logic              sclk_d;
  logic              rise;
  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  bits_q;
  logic [DATA_W-1:0]  out_q;
  logic [LEFT_W-1:0]  left_q;

  assign rise = sclk_s && !sclk_d;

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (sen_s) state_n = ST_SHIFT;
      ST_SHIFT: if (!sen_s) state_n = ST_DIR;
      ST_DIR: begin
        if (sen_s) state_n = ST_SHIFT;
        else if (rise) begin
          if (!sdi_s && int'(bits_q) >= ADDR_W) state_n = ST_RWAIT;
          else                                  state_n = ST_IDLE;
        end
      end
      ST_RWAIT: state_n = ST_LOAD;
      ST_LOAD:  state_n = ST_OUT;
      ST_OUT: begin
        if (sen_s) state_n = ST_SHIFT;
        else if (rise && left_q == LEFT_W'(1)) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sclk_d  <= 1'b0;
      sh_q    <= '0;
      bits_q  <= '0;
      out_q   <= '0;
      left_q  <= '0;
      sdo     <= 1'b0;
      ready   <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      state_q <= state_n;
      sclk_d  <= sclk_s;
      ready   <= (state_n == ST_IDLE);
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      if (state_n == ST_SHIFT && state_q != ST_SHIFT) begin
        bits_q <= '0;
        sdo    <= 1'b0;
      end
      case (state_q)
        ST_SHIFT: begin
          if (sen_s && rise) begin
            sh_q <= {sh_q[FRAME_W-2:0], sdi_s};
            if (int'(bits_q) != FRAME_W) bits_q <= bits_q + BITS_W'(1);
          end
        end
        ST_DIR: begin
          if (!sen_s && rise) begin
            if (sdi_s && int'(bits_q) == FRAME_W) begin
              wr_en   <= 1'b1;
              wr_addr <= sh_q[ADDR_W-1:0];
              wr_data <= sh_q[FRAME_W-1:ADDR_W];
            end else if (!sdi_s && int'(bits_q) >= ADDR_W) begin
              rd_en   <= 1'b1;
              rd_addr <= sh_q[ADDR_W-1:0];
            end
          end
        end
        ST_LOAD: begin
          out_q  <= rd_data;
          left_q <= LEFT_W'(DATA_W);
        end
        ST_OUT: begin
          if (!sen_s && rise) begin
            sdo    <= out_q[DATA_W-1];
            out_q  <= {out_q[DATA_W-2:0], 1'b0};
            left_q <= left_q - LEFT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R3: an open frame always shows busy on the next cycle
  a_r3_busy_in_frame: assert property (@(posedge clk) disable iff (rst)
    sen_s |=> !ready);
  // R2: a commit is a single-cycle strobe
  a_r2_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  // R4: output only moves on a serial clock edge
  a_r4_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OUT && !rise && !sen_s) |=> $stable(sdo));
  // R4: remaining-bit count never exceeds one word
  always_ff @(posedge clk) begin
    if (!rst) a_r4_left_range: assert (int'(left_q) <= DATA_W);
  end
endmodule

// File: rtl/rtc_ser_slave.sv
module rtc_ser_slave #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int MEM_WORDS   = 4,
  parameter int MEM_BASE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sen_i,
  input  logic sdi_i,
  input  logic tick_i,
  output logic sdo_o,
  output logic ready_o
);
  logic [2:0] lines_s;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  rtc_ser_sync #(.NUM(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({sdi_i, sen_i, sclk_i}),
    .dout(lines_s)
  );

  rtc_ser_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst(rst),
    .sclk_s(lines_s[0]), .sen_s(lines_s[1]), .sdi_s(lines_s[2]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sdo(sdo_o), .ready(ready_o)
  );

  rtc_ser_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS),
    .MEM_BASE(MEM_BASE), .CNT_ADDR(0), .ADJ_ADDR(2)
  ) u_regs (
    .clk(clk), .rst(rst), .tick(tick_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/rtc_ser_slave_tb.sv
module rtc_ser_slave_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sen = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic sdo, ready;
  int checks = 0, fails = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;
  logic [31:0] mdl [8];

  always #10 clk = ~clk;

  rtc_ser_slave u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sen_i(sen), .sdi_i(sdi),
    .tick_i(tick), .sdo_o(sdo), .ready_o(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdi = b; wait_clk(4);
    sclk = 1'b1; wait_clk(6);
    sclk = 1'b0; wait_clk(4);
  endtask

  task automatic open_frame();
    quiet = 1'b0;
    chk("R3 ready before frame", {31'd0, ready}, 32'd1);
    sen = 1'b1; wait_clk(6);
    chk("R3 busy in frame", {31'd0, ready}, 32'd0);
  endtask

  task automatic end_quiet();
    sdi = 1'b0; wait_clk(6); quiet = 1'b1;
  endtask

  // R2: data then address, MSB first, direction 1
  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    open_frame();
    for (int i = 31; i >= 0; i--) pulse_bit(d[i]);
    for (int i = 2; i >= 0; i--) pulse_bit(a[i]);
    sdi = 1'b0; sen = 1'b0; wait_clk(4);
    pulse_bit(1'b1);
    if (a != 3'd1 && a != 3'd3) mdl[a] = d;
    end_quiet();
  endtask

  // R4: address only, direction 0, 32 bits out MSB first
  task automatic host_read(input logic [2:0] a, output logic [31:0] v);
    open_frame();
    for (int i = 2; i >= 0; i--) pulse_bit(a[i]);
    sdi = 1'b0; sen = 1'b0; wait_clk(4);
    pulse_bit(1'b0);
    wait_clk(4);
    v = '0;
    for (int i = 0; i < 32; i++) begin
      sdi = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(6);
      v = {v[30:0], sdo};
      sclk = 1'b0; wait_clk(4);
    end
    end_quiet();
  endtask

  task automatic read_chk(input logic [2:0] a, input string req);
    logic [31:0] v;
    host_read(a, v);
    chk(req, v, mdl[a]);
  endtask

  task automatic do_tick();
    tick = 1'b1; wait_clk(1);
    tick = 1'b0; wait_clk(1);
    mdl[0] = mdl[0] + 32'd1;
  endtask

  // R3: per-clock comparison with the model's idle state
  always @(negedge clk) begin
    if (quiet && !rst) chk("R3 idle ready", {31'd0, ready}, 32'd1);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    chk("R1 ready after reset", {31'd0, ready}, 32'd1);
    chk("R1 sdo after reset", {31'd0, sdo}, 32'd0);
    quiet = 1'b1;
    for (int a = 0; a < 8; a++) read_chk(3'(a), "R1 reset value");

    host_write(3'd4, 32'hA5A5_5A5A);
    host_write(3'd5, 32'hFFFF_FFFF);
    host_write(3'd6, 32'h8000_0000);
    host_write(3'd7, 32'h0000_0001);
    host_write(3'd2, 32'h1234_5678);
    for (int a = 4; a < 8; a++) read_chk(3'(a), "R2 R4 retention word");
    read_chk(3'd2, "R6 adjust storage");
    read_chk(3'd0, "R6 counter unaffected by adjust");

    host_write(3'd1, 32'hDEAD_BEEF);
    host_write(3'd3, 32'hCAFE_F00D);
    read_chk(3'd1, "R5 unmapped addr 1 zero");
    read_chk(3'd3, "R5 unmapped addr 3 zero");
    read_chk(3'd5, "R5 neighbour intact");
    read_chk(3'd2, "R5 adjust intact");

    host_write(3'd0, 32'h0000_0100);
    read_chk(3'd0, "R7 counter load");
    for (int i = 0; i < 5; i++) do_tick();
    read_chk(3'd0, "R7 counter ticks");
    host_write(3'd0, 32'hFFFF_FFFF);
    do_tick();
    read_chk(3'd0, "R7 counter wrap");

    // R8: short write frame (10 bits) discarded
    open_frame();
    for (int i = 0; i < 10; i++) pulse_bit(1'b1);
    sdi = 1'b0; sen = 1'b0; wait_clk(4);
    pulse_bit(1'b1);
    end_quiet();
    for (int a = 4; a < 8; a++) read_chk(3'(a), "R8 short write ignored");
    read_chk(3'd0, "R8 counter unchanged");

    // R9: data changing well before each edge still lands correctly
    host_write(3'd6, 32'h0F0F_3C3C);
    read_chk(3'd6, "R9 sampled on rising edge");

    done = 1'b1;
    quiet = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule